// File: doc/BRIEF.md
# Encapsulated CCID UART frame builder

This block turns a command APDU into the byte stream that a host pushes out over a high-speed UART towards a contactless reader. A start strobe arrives with the APDU length. The block then takes exactly that many payload bytes on a valid/ready input and keeps them in an internal store. It then plays out the complete frame on a valid/ready byte output that feeds a UART transmitter.

The frame has a fixed layout:

- a three-byte preamble and start code;
- a CCID bulk-transfer header: a message type, a four-byte little-endian length and five zero parameter bytes;
- the payload;
- a two's-complement checksum;
- a single zero postamble.

The frame is 15 bytes longer than the payload. A start whose length is zero or above the `MAX_LEN` parameter is refused with an error pulse, and no byte is emitted.

Top module: `ccid_frame_tx`

## Requirements
- R1: Every frame begins with the bytes 00, 00, FF at positions 0 to 2 and ends with one 00 byte. A payload of N bytes gives a frame of exactly N+15 bytes.
- R2: Position 3 carries the message type 0x6F. Positions 4 to 7 carry the payload length as a 32-bit value, least significant byte at position 4.
- R3: Positions 8 to 12 are 00. Payload bytes then follow from position 13, in the order they were accepted.
- R4: The byte after the payload equals (256 − S) mod 256, where S is the 8-bit sum of positions 3 through the last payload byte. For the payload FF E1 00 00 04 this byte is A8.
- R5: A start with length 0 or above `MAX_LEN`, given while idle, sets `err_o` for exactly the next cycle. It leaves `busy_o` low, emits nothing and accepts no input.
- R6: `busy_o` rises in the cycle after an accepted start. It stays high until the postamble byte is taken, and is low in the cycle after that handshake.
- R7: While `out_valid_o` is high and `out_ready_i` is low, `out_valid_o` stays high and `out_data_o` holds its value. Stalls lose and repeat no byte.
- R8: A start strobe while `busy_o` is high is ignored, and the frame in progress completes unchanged.
- R9: `in_ready_o` is high only while payload bytes are being collected, and never together with `out_valid_o`. Exactly the announced number of bytes is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame; sampled only while idle |
| len_i | input | LW = $clog2(MAX_LEN+1) | Payload length qualified by start_i |
| in_valid_i | input | 1 | Payload byte valid |
| in_data_i | input | 8 | Payload byte |
| in_ready_o | output | 1 | Block accepts a payload byte |
| out_valid_o | output | 1 | Frame byte valid |
| out_data_o | output | 8 | Frame byte |
| out_ready_i | input | 1 | UART transmitter takes the byte |
| busy_o | output | 1 | A frame is being collected or sent |
| err_o | output | 1 | One-cycle pulse for a refused length |

## Verification
A wrong position counter or phase shows at once as a misplaced header or length byte, or as a frame that is too short or too long. A bad checksum accumulator shows as a single wrong byte just before the postamble. A payload store addressing fault shows as reordered payload bytes, visible on the first frame longer than one byte. Faults in stall handling appear as repeated or missing bytes within the first stalled cycle. Faults in length screening appear as an emission or a missing error pulse one cycle after a bad start.

// File: rtl/ccid_frame_pkg.sv
package ccid_frame_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_EMIT = 2'd2
    } phase_t;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;
    localparam logic [7:0] MSG_XFER  = 8'h6F;
    localparam logic [7:0] ZERO_BYTE = 8'h00;
    localparam int HDR_BYTES  = 13;   // bytes before the payload
    localparam int FRAME_OVHD = 15;   // header + checksum + postamble
endpackage

// File: rtl/ccid_payload_store.sv
module ccid_payload_store #(
    parameter int DEPTH = 255,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    always_comb begin
        if ({1'b0, rd_addr} < (AW+1)'(DEPTH)) rd_data = mem_q[rd_addr];
        else                                   rd_data = 8'h00;
    end
endmodule

// File: rtl/ccid_sum_acc.sv
module ccid_sum_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_en,
    input  logic [7:0] load_val,
    input  logic       add_en,
    input  logic [7:0] add_val,
    output logic [7:0] sum_o
);
    logic [7:0] sum_d, sum_q;

    always_comb begin
        sum_d = sum_q;
        if (load_en)     sum_d = load_val;
        else if (add_en) sum_d = sum_q + add_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sum_q <= 8'h00;
        else        sum_q <= sum_d;
    end

    assign sum_o = sum_q;
endmodule

// File: rtl/ccid_frame_byte.sv
module ccid_frame_byte
    import ccid_frame_pkg::*;
#(
    parameter int LW = 8,
    parameter int PW = 9,
    parameter int AW = 8
) (
    input  logic [PW-1:0] pos_i,
    input  logic [LW-1:0] len_i,
    input  logic [7:0]    sum_i,
    input  logic [7:0]    pay_i,
    output logic [AW-1:0] rd_addr_o,
    output logic [7:0]    byte_o,
    output logic          last_o
);
    logic [31:0] len_wide;
    logic [7:0]  len_b [4];
    logic [PW-1:0] pay_end;
    logic [PW-1:0] pay_off;

    assign len_wide = 32'(len_i);

    for (genvar g = 0; g < 4; g++) begin : g_len_b
        assign len_b[g] = len_wide[8*g +: 8];
    end

    always_comb begin
        pay_end   = PW'(HDR_BYTES) + PW'(len_i);
        pay_off   = pos_i - PW'(HDR_BYTES);
        rd_addr_o = AW'(pay_off);
        last_o    = (pos_i == pay_end + PW'(1));
        if (pos_i < PW'(2))               byte_o = ZERO_BYTE;
        else if (pos_i == PW'(2))         byte_o = SYNC_BYTE;
        else if (pos_i == PW'(3))         byte_o = MSG_XFER;
        else if (pos_i < PW'(8))          byte_o = len_b[pos_i[1:0]];
        else if (pos_i < PW'(HDR_BYTES))  byte_o = ZERO_BYTE;
        else if (pos_i < pay_end)         byte_o = pay_i;
        else if (pos_i == pay_end)        byte_o = 8'h00 - sum_i;
        else                              byte_o = ZERO_BYTE;
    end
endmodule

// File: rtl/ccid_frame_tx.sv
module ccid_frame_tx
    import ccid_frame_pkg::*;
#(
    parameter int MAX_LEN = 255,
    parameter int LW = $clog2(MAX_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [LW-1:0] len_i,
    input  logic          in_valid_i,
    input  logic [7:0]    in_data_i,
    output logic          in_ready_o,
    output logic          out_valid_o,
    output logic [7:0]    out_data_o,
    input  logic          out_ready_i,
    output logic          busy_o,
    output logic          err_o
);
    localparam int AW = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
    localparam int PW = $clog2(MAX_LEN + FRAME_OVHD);

    typedef struct packed {
        phase_t        phase;
        logic [LW-1:0] len;
        logic [LW-1:0] cnt;
        logic [PW-1:0] pos;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          sum_load, sum_add;
    logic [7:0]    sum_init, sum_q;
    logic          wr_en;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;
    logic [7:0]    frame_byte;
    logic          frame_last;
    logic [31:0]   start_len_wide;

    assign start_len_wide = 32'(len_i);
    assign sum_init = MSG_XFER + start_len_wide[7:0] + start_len_wide[15:8]
                    + start_len_wide[23:16] + start_len_wide[31:24];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.err = 1'b0;
        sum_load  = 1'b0;
        sum_add   = 1'b0;
        wr_en     = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    if (len_i == '0 || len_i > LW'(MAX_LEN)) begin
                        ctl_d.err = 1'b1;
                    end else begin
                        ctl_d.phase = PH_LOAD;
                        ctl_d.len   = len_i;
                        ctl_d.cnt   = '0;
                        sum_load    = 1'b1;
                    end
                end
            end
            PH_LOAD: begin
                if (in_valid_i) begin
                    wr_en   = 1'b1;
                    sum_add = 1'b1;
                    if (ctl_q.cnt == ctl_q.len - LW'(1)) begin
                        ctl_d.phase = PH_EMIT;
                        ctl_d.pos   = '0;
                    end else begin
                        ctl_d.cnt = ctl_q.cnt + LW'(1);
                    end
                end
            end
            PH_EMIT: begin
                if (out_ready_i) begin
                    if (frame_last) ctl_d.phase = PH_IDLE;
                    else            ctl_d.pos   = ctl_q.pos + PW'(1);
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    ccid_payload_store #(.DEPTH(MAX_LEN), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (AW'(ctl_q.cnt)),
        .wr_data (in_data_i),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    ccid_sum_acc u_sum (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (sum_load),
        .load_val (sum_init),
        .add_en   (sum_add),
        .add_val  (in_data_i),
        .sum_o    (sum_q)
    );

    ccid_frame_byte #(.LW(LW), .PW(PW), .AW(AW)) u_byte (
        .pos_i     (ctl_q.pos),
        .len_i     (ctl_q.len),
        .sum_i     (sum_q),
        .pay_i     (rd_data),
        .rd_addr_o (rd_addr),
        .byte_o    (frame_byte),
        .last_o    (frame_last)
    );

    assign in_ready_o  = (ctl_q.phase == PH_LOAD);
    assign out_valid_o = (ctl_q.phase == PH_EMIT);
    assign out_data_o  = frame_byte;
    assign busy_o      = (ctl_q.phase != PH_IDLE);
    assign err_o       = ctl_q.err;
endmodule

// File: rtl/ccid_frame_tx_chk.sv
module ccid_frame_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start_i,
    input logic       in_ready_o,
    input logic       out_valid_o,
    input logic [7:0] out_data_o,
    input logic       out_ready_i,
    input logic       busy_o,
    input logic       err_o
);
    // R7
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

    // R6
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && !(out_valid_o && out_ready_i) |=> busy_o);

    // R5
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o);

    // R5
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !busy_o && $past(start_i));

    // R9
    load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> busy_o && !out_valid_o);

    // R1
    post_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(out_valid_o && out_ready_i) && $past(out_data_o) == 8'h00);
endmodule

bind ccid_frame_tx ccid_frame_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_ready_o  (in_ready_o),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_ready_i (out_ready_i),
    .busy_o      (busy_o),
    .err_o       (err_o)
);

// File: tb/ccid_frame_tx_test.sv
module ccid_frame_tx_test;
    localparam int MAXL = 20;
    localparam int LW   = $clog2(MAXL + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [LW-1:0] len_i = '0;
    logic          in_valid_i = 1'b0;
    logic [7:0]    in_data_i = 8'h00;
    logic          in_ready_o;
    logic          out_valid_o;
    logic [7:0]    out_data_o;
    logic          out_ready_i = 1'b0;
    logic          busy_o;
    logic          err_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [7:0] dat [0:31];
    logic [7:0] got [0:63];

    always #4 clk = ~clk;

    ccid_frame_tx #(.MAX_LEN(MAXL)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .len_i(len_i),
        .in_valid_i(in_valid_i), .in_data_i(in_data_i), .in_ready_o(in_ready_o),
        .out_valid_o(out_valid_o), .out_data_o(out_data_o), .out_ready_i(out_ready_i),
        .busy_o(busy_o), .err_o(err_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_byte(input int len, input int p);
        int s;
        if (p < 2) return 8'h00;
        if (p == 2) return 8'hFF;
        if (p == 3) return 8'h6F;
        if (p == 4) return 8'(len);
        if (p < 13) return 8'h00;
        if (p < 13 + len) return dat[p-13];
        if (p == 13 + len) begin
            s = 'h6F + len;
            for (int k = 0; k < len; k++) s += dat[k];
            return 8'((256 - (s % 256)) % 256);
        end
        return 8'h00;
    endfunction

    function automatic string tag_of(input int len, input int p);
        if (p < 3 || p == len + 14) return "R1";
        if (p < 8) return "R2";
        if (p < 13 + len) return "R3";
        return "R4";
    endfunction

    task automatic run_frame(input int len, input int stall, input bit inject);
        int idx_in, idx_out, cyc;
        bit held;
        logic [7:0] held_byte;
        bit excl_ok;
        idx_in = 0; idx_out = 0; cyc = 0; held = 0; held_byte = 8'h00; excl_ok = 1;
        @(negedge clk);
        start_i = 1'b1; len_i = LW'(len);
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1, "R6 busy after start", busy_o, 1);
        while (idx_out < len + 15 && cyc < 400) begin
            if (inject && cyc == 1) begin start_i = 1'b1; len_i = LW'(3); end
            else start_i = 1'b0;
            in_valid_i = (idx_in < len) && !(stall != 0 && cyc % 3 == 1);
            in_data_i  = (idx_in < len) ? dat[idx_in] : 8'h5A;
            if (in_ready_o && out_valid_o) excl_ok = 0;
            out_ready_i = !(stall != 0 && (cyc % 4 == 2 || cyc % 7 == 3));
            if (held) check(out_valid_o && out_data_o == held_byte, "R7 hold", out_data_o, held_byte);
            held = out_valid_o && !out_ready_i;
            held_byte = out_data_o;
            if (in_valid_i && in_ready_o) idx_in++;
            if (out_valid_o && out_ready_i) begin got[idx_out] = out_data_o; idx_out++; end
            @(posedge clk); @(negedge clk);
            cyc++;
        end
        start_i = 1'b0; in_valid_i = 1'b0; out_ready_i = 1'b0;
        check(busy_o == 1'b0, "R6 busy low after postamble", busy_o, 0);
        check(out_valid_o == 1'b0, "R1 no extra byte", out_valid_o, 0);
        check(idx_in == len, "R9 bytes accepted", idx_in, len);
        check(excl_ok, "R9 in_ready with out_valid", 0, 1);
        check(idx_out == len + 15, "R1 frame length", idx_out, len + 15);
        for (int p = 0; p < idx_out; p++)
            check(got[p] == exp_byte(len, p), tag_of(len, p), got[p], exp_byte(len, p));
        if (inject) check(idx_out == len + 15 && got[4] == 8'(len), "R8 start ignored", got[4], len);
    endtask

    task automatic bad_start(input int len);
        @(negedge clk);
        start_i = 1'b1; len_i = LW'(len);
        @(posedge clk); @(negedge clk);
        start_i = 1'b0;
        check(err_o == 1'b1, "R5 err pulse", err_o, 1);
        check(busy_o == 1'b0, "R5 busy stays low", busy_o, 0);
        @(posedge clk); @(negedge clk);
        check(err_o == 1'b0, "R5 err one cycle", err_o, 0);
        for (int k = 0; k < 4; k++) begin
            check(!out_valid_o && !in_ready_o, "R5 nothing emitted", out_valid_o, 0);
            @(posedge clk); @(negedge clk);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!busy_o && !out_valid_o && !in_ready_o && !err_o, "R6 reset state", busy_o, 0);
        rst_n = 1'b1;
        // R4 worked example
        dat[0] = 8'hFF; dat[1] = 8'hE1; dat[2] = 8'h00; dat[3] = 8'h00; dat[4] = 8'h04;
        run_frame(5, 0, 0);
        check(got[18] == 8'hA8, "R4 example checksum", got[18], 8'hA8);
        check(got[19] == 8'h00, "R1 example postamble", got[19], 0);
        // sweep every legal length, with and without stalls
        for (int l = 1; l <= MAXL; l++) begin
            for (int m = 0; m < 2; m++) begin
                for (int k = 0; k < 32; k++) dat[k] = 8'((k * 37 + l * 11 + m * 90 + 'hA5) % 256);
                run_frame(l, m, (l % 4 == 1) && m == 1);
            end
        end
        // all-FF payload drives the sum hard
        for (int k = 0; k < 32; k++) dat[k] = 8'hFF;
        run_frame(MAXL, 1, 0);
        bad_start(0);
        bad_start(MAXL + 1);
        bad_start((1 << LW) - 1);
        for (int k = 0; k < 32; k++) dat[k] = 8'(k);
        run_frame(2, 1, 1);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule